// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Plane

This block is a combinational logic plane whose connections come from a configuration word, not from fixed wiring. The word takes the place of fuse links. The plane sees sixteen literal sources: four dedicated inputs, four inputs that come back from the bidirectional lines, and eight register feedback bits. Each source is available in true and in inverted form. The plane forms 32 logic product terms and 13 control product terms. A complement-array NOR collects any chosen subset of the logic terms, and its output is offered to every product term as a seventeenth source.

From the logic terms the block builds three kinds of output. It makes four bidirectional-line outputs, each an OR of chosen terms followed by a polarity XOR. It makes J and K sums for eight external registers. The control terms give the line direction enables, register load enables, group preset and reset, and one output enable. The registers, the clock tree of those registers and the pad drivers stay outside the block.

The configuration enters serially while `cfg_valid` is low. While loading is in progress, or while the loaded word contains a combinational loop through the NOR, every functional output is held inactive.

Top module: `sop_plane`

## Requirements
- R1: Reset clears the configuration to all zeros. With an all-zero configuration and `cfg_valid` high, the outputs are as follows:
  - `reg_j`, `reg_k`, `grp_preset`, `grp_reset`, `grp_load`, `bio_out` and `bio_drive` are all 0, so every line acts as an input.
  - `out_en` is 1.
  - `cfg_err` is 0.
- R2: On each clock edge where `cfg_shift` is 1 and `cfg_valid` is 0, the configuration shifts one place towards bit 0, and `cfg_din` enters at bit 2205.
  - After 2206 such shifts, the first bit sent sits at bit 0.
  - `cfg_shift` has no effect while `cfg_valid` is 1.
- R3: While `cfg_valid` is 0, every output except `cfg_err` is 0.
- R4: The configuration holds 45 fields of 34 bits each. Product term t (0..44) starts at bit 34·t.
  - Literal source s has its true-form bit at 34·t+2s and its complement-form bit at 34·t+2s+1.
  - The sources are numbered as follows: s = 0..3 are `ded_in`, s = 4..7 are `bio_in`, s = 8..15 are `fb_in`, and s = 16 is the complement-array output.
  - A term is the AND of its connected literals.
- R5: A term that connects both forms of one source is 0. A term with no connected literal is 0.
- R6: The complement-array output is the NOR of the logic terms t (0..31) whose select bit 1530+t is set. It is 1 when no term is selected.
- R7: `cfg_err` is 1 exactly when some logic term is selected into the NOR and also connects either form of source 16. While `cfg_err` is 1, all other outputs are 0.
- R8: The line output `bio_out[i]` is the OR of the logic terms t whose bit 1562+32·i+t is set, XORed with the polarity bit 1690+i.
- R9: `reg_j[r]` is the OR of the logic terms t whose bit 1694+32·r+t is set. `reg_k[r]` is the OR of the logic terms t whose bit 1950+32·r+t is set.
- R10: The control terms drive the outputs as follows:
  - Term 32 drives `grp_preset[0]`, term 33 drives `grp_reset[0]`, term 34 drives `grp_preset[1]` and term 35 drives `grp_reset[1]`.
  - Terms 36..39 drive `bio_drive[0..3]`.
  - Terms 40..43 drive `grp_load[0..3]`.
  - Term 44 drives `out_en`, except that `out_en` is 1 when term 44 has no connection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | High once the configuration is complete; low allows shifting |
| cfg_shift | input | 1 | Shift strobe for serial loading |
| cfg_din | input | 1 | Serial configuration bit |
| ded_in | input | 4 | Dedicated logic inputs |
| bio_in | input | 4 | Values seen on the bidirectional lines |
| fb_in | input | 8 | Register feedback bits |
| bio_out | output | 4 | Polarity-adjusted line outputs |
| bio_drive | output | 4 | Per-line output enable (1 = drive) |
| reg_j | output | 8 | J sums for the eight registers |
| reg_k | output | 8 | K sums for the eight registers |
| grp_preset | output | 2 | Preset for registers 0..3 and 4..7 |
| grp_reset | output | 2 | Reset for registers 0..3 and 4..7 |
| grp_load | output | 4 | Load enable, one per register pair |
| out_en | output | 1 | Register output enable |
| cfg_err | output | 1 | Loop-forming configuration detected |

## Verification
Four configurations are loaded through the serial path.

- **Mixed configuration.** It combines plain literal terms, a self-contradicting term, terms that use the true and the inverted NOR output, and both line polarities. It is then swept with random sixteen-bit input words. This separates literal polarity errors, the wrong NOR subset and swapped J/K or control routing.
- **Loop configuration.** The same word with one extra NOR selection shows that loop detection silences everything.
- **Sparse configuration.** It leaves the output-enable term empty, which exercises the NOR with nothing selected.
- **Bit ordering and gating.** Every cycle of every load is compared, and shift strobes are then applied while `cfg_valid` is high. These catch bit-order slips and shift gating faults.

A mid-run reset returns the block to the all-zero state.

// File: rtl/sop_pkg.sv
package sop_pkg;

   // width of one product-term field: true/complement pair per source plus the NOR source
   function automatic int term_field_bits(int n_src);
      return 2 * (n_src + 1);
   endfunction

   // control terms: two preset/reset pairs, one direction term per line,
   // one load term per register pair, one output-enable term
   function automatic int ctrl_term_count(int n_line, int n_reg);
      return 4 + n_line + n_reg / 2 + 1;
   endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] q
);

   initial begin
      assert (W >= 2) else $error("sop_cfg_chain: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (shift_en) q <= {din, q[W-1:1]};
   end

   // R2: new bit lands at the top
   a_r2_bit_enters: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> q[W-1] == $past(din));

   // R2: old contents move one place down
   a_r2_word_moves: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> q[W-2:0] == $past(q[W-1:1]));

   // R2: no strobe, no change
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(q));

endmodule

// File: rtl/sop_term.sv
module sop_term #(
   parameter int NS = 16
) (
   input  logic [NS-1:0]   sig,
   input  logic [2*NS-1:0] conn,
   output logic            hit
);

   logic used;
   logic ok;

   always_comb begin
      used = |conn;
      ok   = 1'b1;
      for (int s = 0; s < NS; s++) begin
         if (conn[2*s]   && !sig[s]) ok = 1'b0;
         if (conn[2*s+1] &&  sig[s]) ok = 1'b0;
      end
      hit = used & ok;
      // R5: a literal wired in both forms can never let the term through
      for (int s = 0; s < NS; s++) begin
         if (conn[2*s] && conn[2*s+1])
            a_r5_both_forms: assert (!hit) else $error("term fired with both forms of a source");
      end
   end

endmodule

// File: rtl/sop_sum.sv
module sop_sum #(
   parameter int N = 32
) (
   input  logic [N-1:0] terms,
   input  logic [N-1:0] sel,
   input  logic         inv,
   output logic         y
);

   assign y = (|(terms & sel)) ^ inv;

endmodule

// File: rtl/sop_plane.sv
module sop_plane
   import sop_pkg::*;
#(
   parameter int N_DED = 4,
   parameter int N_BIO = 4,
   parameter int N_FB  = 8,
   parameter int N_LT  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_valid,
   input  logic               cfg_shift,
   input  logic               cfg_din,
   input  logic [N_DED-1:0]   ded_in,
   input  logic [N_BIO-1:0]   bio_in,
   input  logic [N_FB-1:0]    fb_in,
   output logic [N_BIO-1:0]   bio_out,
   output logic [N_BIO-1:0]   bio_drive,
   output logic [N_FB-1:0]    reg_j,
   output logic [N_FB-1:0]    reg_k,
   output logic [1:0]         grp_preset,
   output logic [1:0]         grp_reset,
   output logic [N_FB/2-1:0]  grp_load,
   output logic               out_en,
   output logic               cfg_err
);

   localparam int N_SIG   = N_DED + N_BIO + N_FB;
   localparam int CA      = N_SIG;
   localparam int TW      = term_field_bits(N_SIG);
   localparam int N_CT    = ctrl_term_count(N_BIO, N_FB);
   localparam int N_PT    = N_LT + N_CT;
   localparam int N_GRP   = N_FB / 2;
   localparam int OFS_NOR = N_PT * TW;
   localparam int OFS_BIO = OFS_NOR + N_LT;
   localparam int OFS_POL = OFS_BIO + N_BIO * N_LT;
   localparam int OFS_J   = OFS_POL + N_BIO;
   localparam int OFS_K   = OFS_J + N_FB * N_LT;
   localparam int CFG_W   = OFS_K + N_FB * N_LT;
   localparam int CT_PR   = N_LT;
   localparam int CT_DIR  = CT_PR + 4;
   localparam int CT_LD   = CT_DIR + N_BIO;
   localparam int CT_OE   = CT_LD + N_GRP;

   initial begin
      assert (N_FB >= 2 && N_FB % 2 == 0) else $error("sop_plane: N_FB must be even and >= 2");
      assert (N_LT >= 1) else $error("sop_plane: N_LT must be positive");
      assert (N_BIO >= 1 && N_DED >= 1) else $error("sop_plane: N_BIO and N_DED must be positive");
      assert (CT_OE == N_PT - 1) else $error("sop_plane: control term map inconsistent");
   end

   // ---------------- configuration store ----------------
   logic [CFG_W-1:0] cfg;

   sop_cfg_chain #(.W(CFG_W)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_shift & ~cfg_valid),
      .din      (cfg_din),
      .q        (cfg)
   );

   // ---------------- literal sources ----------------
   logic [N_SIG-1:0] src;
   logic [N_SIG:0]   src_ca;
   logic [N_LT-1:0]  pre_hit;
   logic [N_LT-1:0]  nor_sel;
   logic [N_LT-1:0]  loop_hit;
   logic             ca;
   logic [N_PT-1:0]  pt;
   logic [N_LT-1:0]  lt;

   assign src     = {fb_in, bio_in, ded_in};
   assign nor_sel = cfg[OFS_NOR +: N_LT];

   // first pass without the NOR source: only these feed the NOR
   for (genvar t = 0; t < N_LT; t++) begin : g_pre
      sop_term #(.NS(N_SIG)) u_pre (
         .sig  (src),
         .conn (cfg[t*TW +: 2*N_SIG]),
         .hit  (pre_hit[t])
      );
      assign loop_hit[t] = nor_sel[t] & (cfg[t*TW + 2*CA] | cfg[t*TW + 2*CA + 1]);
   end

   assign ca     = ~|(pre_hit & nor_sel);
   assign src_ca = {ca, src};

   for (genvar t = 0; t < N_PT; t++) begin : g_pt
      sop_term #(.NS(N_SIG + 1)) u_pt (
         .sig  (src_ca),
         .conn (cfg[t*TW +: TW]),
         .hit  (pt[t])
      );
   end

   assign lt = pt[N_LT-1:0];

   // ---------------- sums ----------------
   logic [N_BIO-1:0] bio_raw;
   logic [N_FB-1:0]  j_raw;
   logic [N_FB-1:0]  k_raw;

   for (genvar i = 0; i < N_BIO; i++) begin : g_line
      sop_sum #(.N(N_LT)) u_line (
         .terms (lt),
         .sel   (cfg[OFS_BIO + i*N_LT +: N_LT]),
         .inv   (cfg[OFS_POL + i]),
         .y     (bio_raw[i])
      );
   end

   for (genvar r = 0; r < N_FB; r++) begin : g_reg
      sop_sum #(.N(N_LT)) u_j (
         .terms (lt),
         .sel   (cfg[OFS_J + r*N_LT +: N_LT]),
         .inv   (1'b0),
         .y     (j_raw[r])
      );
      sop_sum #(.N(N_LT)) u_k (
         .terms (lt),
         .sel   (cfg[OFS_K + r*N_LT +: N_LT]),
         .inv   (1'b0),
         .y     (k_raw[r])
      );
   end

   // ---------------- output gating ----------------
   logic active;
   logic oe_used;

   assign cfg_err = |loop_hit;
   assign active  = cfg_valid & ~cfg_err;
   assign oe_used = |cfg[CT_OE*TW +: TW];

   assign bio_out    = active ? bio_raw : '0;
   assign bio_drive  = active ? pt[CT_DIR +: N_BIO] : '0;
   assign reg_j      = active ? j_raw : '0;
   assign reg_k      = active ? k_raw : '0;
   assign grp_preset = active ? {pt[CT_PR+2], pt[CT_PR]}   : 2'b00;
   assign grp_reset  = active ? {pt[CT_PR+3], pt[CT_PR+1]} : 2'b00;
   assign grp_load   = active ? pt[CT_LD +: N_GRP] : '0;
   assign out_en     = active & (oe_used ? pt[CT_OE] : 1'b1);

   // R3: nothing leaves the block while loading
   a_r3_quiet_loading: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_valid |-> (bio_out == '0 && bio_drive == '0 && reg_j == '0 && reg_k == '0
                      && grp_preset == 2'b00 && grp_reset == 2'b00 && grp_load == '0 && !out_en));

   // R7: a looping configuration silences every output
   a_r7_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (bio_out == '0 && bio_drive == '0 && reg_j == '0 && reg_k == '0
                   && grp_preset == 2'b00 && grp_reset == 2'b00 && grp_load == '0 && !out_en));

   // R1: reset leaves no loop flagged
   a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !cfg_err);

endmodule

// File: tb/tb_sop_plane.sv
`timescale 1ns/1ps
module tb_sop_plane;

   localparam int TW      = 34;
   localparam int NPT     = 45;
   localparam int OFS_NOR = NPT * TW;
   localparam int OFS_BIO = OFS_NOR + 32;
   localparam int OFS_POL = OFS_BIO + 128;
   localparam int OFS_J   = OFS_POL + 4;
   localparam int OFS_K   = OFS_J + 256;
   localparam int TOT     = OFS_K + 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_valid = 1'b0;
   logic cfg_shift = 1'b0;
   logic cfg_din = 1'b0;
   logic [3:0] ded_in = '0;
   logic [3:0] bio_in = '0;
   logic [7:0] fb_in = '0;
   logic [3:0] bio_out, bio_drive;
   logic [7:0] reg_j, reg_k;
   logic [1:0] grp_preset, grp_reset;
   logic [3:0] grp_load;
   logic out_en, cfg_err;

   always #2 clk = ~clk;

   sop_plane dut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_shift(cfg_shift),
      .cfg_din(cfg_din), .ded_in(ded_in), .bio_in(bio_in), .fb_in(fb_in),
      .bio_out(bio_out), .bio_drive(bio_drive), .reg_j(reg_j), .reg_k(reg_k),
      .grp_preset(grp_preset), .grp_reset(grp_reset), .grp_load(grp_load),
      .out_en(out_en), .cfg_err(cfg_err)
   );

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;
   bit [TOT-1:0] mcfg = '0;
   bit [TOT-1:0] img  = '0;

   // one product term evaluated from the requirement text
   function automatic bit term_val(bit [TOT-1:0] c, int t, logic [15:0] sg, bit cval, bit incl);
      bit conn = 1'b0;
      bit v = 1'b1;
      for (int s = 0; s < 17; s++) begin
         bit x, tb, cb;
         if (s == 16 && !incl) continue;
         x  = (s == 16) ? cval : sg[s];
         tb = c[t*TW + 2*s];
         cb = c[t*TW + 2*s + 1];
         if (tb || cb) conn = 1'b1;
         if (tb && !x) v = 1'b0;
         if (cb && x)  v = 1'b0;
      end
      return conn && v;
   endfunction

   function automatic logic [33:0] model(bit [TOT-1:0] c, logic [15:0] sg, bit v);
      bit err = 1'b0;
      bit cc = 1'b1;
      bit oe_used = 1'b0;
      bit [44:0] t;
      bit [3:0] bo, dr, ld;
      bit [7:0] j, k;
      bit [1:0] pr, rs;
      bit oen;
      for (int i = 0; i < 32; i++)
         if (c[OFS_NOR+i] && (c[i*TW+32] || c[i*TW+33])) err = 1'b1;
      for (int i = 0; i < 32; i++)
         if (c[OFS_NOR+i] && term_val(c, i, sg, 1'b0, 1'b0)) cc = 1'b0;
      for (int i = 0; i < 45; i++) t[i] = term_val(c, i, sg, cc, 1'b1);
      for (int s = 0; s < TW; s++) if (c[44*TW+s]) oe_used = 1'b1;
      for (int i = 0; i < 4; i++) begin
         bo[i] = (|(t[31:0] & c[OFS_BIO+i*32 +: 32])) ^ c[OFS_POL+i];
         dr[i] = t[36+i];
         ld[i] = t[40+i];
      end
      for (int r = 0; r < 8; r++) begin
         j[r] = |(t[31:0] & c[OFS_J+r*32 +: 32]);
         k[r] = |(t[31:0] & c[OFS_K+r*32 +: 32]);
      end
      pr  = {t[34], t[32]};
      rs  = {t[35], t[33]};
      oen = oe_used ? t[44] : 1'b1;
      if (!v || err) return {err, 33'b0};
      return {err, oen, ld, rs, pr, k, j, dr, bo};
   endfunction

   task automatic step(input logic [15:0] sg, input bit v, input bit sh, input bit b, input string tag);
      logic [33:0] got, exp;
      @(negedge clk);
      {fb_in, bio_in, ded_in} = sg;
      cfg_valid = v;
      cfg_shift = sh;
      cfg_din   = b;
      #1;
      got = {cfg_err, out_en, grp_load, grp_reset, grp_preset, reg_k, reg_j, bio_drive, bio_out};
      exp = model(mcfg, sg, v);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s: in=%h got=%h expected=%h", tag, sg, got, exp);
      end
      @(posedge clk);
      if (sh && !v) mcfg = {b, mcfg[TOT-1:1]};
   endtask

   task automatic load_img(input string tag);
      for (int i = 0; i < TOT; i++) step(16'(i * 37), 1'b0, 1'b1, img[i], tag);
   endtask

   task automatic sweep(input int n, input string tag);
      for (int i = 0; i < n; i++) step(16'($urandom), 1'b1, 1'b0, 1'b0, tag);
   endtask

   task automatic conn(input int t, input int s, input bit comp);
      img[t*TW + 2*s + comp] = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1, R3: after reset, loading mode, everything quiet
      step(16'hffff, 1'b0, 1'b0, 1'b0, "R3 reset quiet");
      // R1: virgin state with valid high
      sweep(20, "R1 virgin");

      // ---- mixed configuration ----
      img = '0;
      conn(0, 0, 0); conn(0, 1, 1);            // R4: ded0 & ~ded1
      conn(1, 11, 0); conn(1, 6, 1);           // R4: fb3 & ~bio2
      conn(2, 0, 0); conn(2, 0, 1);            // R5: contradiction
      conn(3, 16, 0); conn(3, 3, 0);           // R6: C & ded3
      conn(4, 16, 1);                          // R6: ~C
      img[OFS_NOR+0] = 1'b1; img[OFS_NOR+1] = 1'b1;
      img[OFS_BIO+0*32+0] = 1'b1; img[OFS_BIO+0*32+1] = 1'b1;   // R8
      img[OFS_BIO+1*32+0] = 1'b1; img[OFS_POL+1] = 1'b1;
      img[OFS_BIO+2*32+3] = 1'b1;
      img[OFS_BIO+3*32+4] = 1'b1; img[OFS_POL+3] = 1'b1;
      img[OFS_J+0*32+0] = 1'b1; img[OFS_K+0*32+2] = 1'b1;       // R9
      img[OFS_J+1*32+3] = 1'b1; img[OFS_J+1*32+1] = 1'b1;
      img[OFS_K+5*32+4] = 1'b1; img[OFS_J+7*32+1] = 1'b1;
      conn(32, 8, 0);                          // R10 preset group 0
      conn(33, 9, 1); conn(33, 2, 0);          // R10 reset group 0
      conn(36, 2, 0);                          // R10 direction line 0
      conn(38, 4, 1);                          // R10 direction line 2
      conn(41, 7, 0);                          // R10 load pair 1
      conn(44, 3, 1);                          // R10 output enable
      load_img("R2 R3 load mixed");
      sweep(600, "R4 R5 R6 R8 R9 R10 mixed");

      // R2: shift strobes ignored while valid is high
      for (int i = 0; i < 100; i++) step(16'($urandom), 1'b1, 1'b1, 1'($urandom), "R2 shift ignored");

      // ---- loop configuration ----
      img[OFS_NOR+3] = 1'b1;
      load_img("R2 load loop");
      sweep(200, "R7 loop");

      // ---- sparse configuration ----
      img = '0;
      conn(5, 15, 0);                          // fb7
      conn(6, 16, 1);                          // ~C with empty NOR: always 0
      img[OFS_BIO+0*32+5] = 1'b1; img[OFS_POL+0] = 1'b1;
      img[OFS_BIO+1*32+6] = 1'b1;
      img[OFS_K+2*32+5] = 1'b1;
      conn(35, 10, 0);                         // reset group 1
      conn(34, 5, 1);                          // preset group 1
      conn(43, 0, 0);                          // load pair 3
      conn(39, 13, 0);                         // direction line 3
      load_img("R2 load sparse");
      sweep(400, "R6 R8 R10 sparse");

      // R1: reset mid run returns the all-zero configuration
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk);
      mcfg = '0;
      @(negedge clk) rst_n = 1'b1;
      sweep(30, "R1 reset again");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: got=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule